// File: doc/BRIEF.md
# T1 Framing-Loss Monitor and Resynchronisation Controller

This block sits beside the receive framer of a T1 line interface. It watches the framing-bit decisions and decides when alignment has been lost. The framer presents each framing bit as a one-cycle strobe with an error flag. The block keeps a short history of those flags and declares out-of-frame when two errors fall inside a selectable window of four, five or six framing bits. A new search can be launched in three ways: by a rising edge on a software request bit, automatically when out-of-frame is declared, or automatically on the rising edge of receive carrier loss. Each launch is signalled to the pattern-search logic by a one-cycle start pulse.

While a search runs, the search logic reports each candidate framing bit as a match or a mismatch strobe. The block counts consecutive matches. When the count reaches the selected length of 10 or 24, it clears out-of-frame and raises in-sync. The mode-dependent search criterion bit is passed straight through to the search logic. All configuration arrives as one static control byte.

The framing-bit and candidate inputs are valid-only streams with no ready. The block accepts every strobe in the cycle it appears and never applies back-pressure, so an upstream source never has to hold a strobe.

Top module: `t1_oof_monitor`

## Requirements
- R1: After reset, oof is 1, in_sync is 0 and resync_start is 0, and the block stays idle until a resync is requested.
- R2: A resync_start pulse follows one cycle after the cycle in which ctrl_byte bit 0 is sampled at 1 having been 0 on the previous cycle; holding bit 0 at 1 never launches another one.
- R3: While in frame, an error on a framing-bit strobe that leaves at least 2 errors among the most recent N strobes raises oof on the next cycle. N is 4 for ctrl_byte bits 5:4 = 00, 5 for 01, and 6 for 10 or 11. Framing strobes received while oof is high are not counted.
- R4: With ctrl_byte bit 1 at 0, an out-of-frame declaration also produces resync_start in the same cycle that oof rises. With bit 1 at 1, only the software bit can start a search.
- R5: With bit 1 at 0 and ctrl_byte bit 6 at 0, a rising edge of carrier_loss produces resync_start one cycle later and sets oof. With bit 6 at 1, carrier_loss has no effect.
- R6: During a search, each matching candidate strobe adds one to a qualification count and a mismatch returns it to 0. The count target is 10 for ctrl_byte bit 2 = 0 and 24 for bit 2 = 1. On the cycle after the strobe that reaches the target, oof falls and in_sync rises.
- R7: Software and automatic triggers in the same cycle give exactly one resync_start pulse. A trigger during a search restarts the count from 0.
- R8: The error history is emptied whenever a search starts and whenever a new alignment is qualified, so earlier errors cannot bring a second declaration early.
- R9: search_crit follows ctrl_byte bit 3 at all times. Bit 7 is reserved and has no effect on any output.
- R10: oof and in_sync are never high together, and oof stays high until a qualification completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_byte | input | 8 | Control byte: 0 soft resync, 1 auto-resync disable, 2 long qualification, 3 search criterion, 5:4 window select, 6 OOF-only trigger, 7 reserved |
| fbit_valid | input | 1 | Framing-bit strobe |
| fbit_err | input | 1 | The strobed framing bit was in error |
| carrier_loss | input | 1 | Receive carrier loss level |
| cand_valid | input | 1 | Candidate framing-bit strobe during search |
| cand_match | input | 1 | Candidate matched (1) or mismatched (0) |
| oof | output | 1 | Out-of-frame level |
| resync_start | output | 1 | One-cycle search launch pulse |
| in_sync | output | 1 | New alignment qualified |
| search_crit | output | 1 | Search criterion passed to the search logic |

## Verification
Every result is registered once. oof, resync_start and in_sync respond on the first clock edge after the input cycle that causes them; the edges are taken against the previous sampled value. search_crit is combinational and follows in the same cycle. The bench steps a behavioural reference model on that same edge and compares all four outputs at the following falling edge, so each response is checked in exactly the cycle it is due. Directed sequences cover each window depth, both qualification lengths, mismatch restarts, held request levels and coincident triggers.

// File: rtl/t1oof_pkg.sv
package t1oof_pkg;

  // Control byte layout: the field order is the order the search logic decodes.
  typedef struct packed {
    logic       rsvd;          // bit 7
    logic       oof_only;      // bit 6: 1 = carrier loss does not trigger
    logic [1:0] win_sel;       // bits 5:4
    logic       crit;          // bit 3
    logic       long_qual;     // bit 2
    logic       auto_off;      // bit 1: active-low auto-resync enable
    logic       sw_req;        // bit 0
  } ctrl_t;

  // Window depth from the select code; codes 2 and 3 share the widest depth.
  function automatic int unsigned win_depth(input logic [1:0] sel,
                                            input int unsigned base);
    case (sel)
      2'd0:    return base;
      2'd1:    return base + 1;
      default: return base + 2;
    endcase
  endfunction

endpackage

// File: rtl/t1oof_err_window.sv
module t1oof_err_window #(
  parameter int unsigned BASE_WIN = 4,
  parameter int unsigned ERR_LIM  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       shift_en,
  input  logic       err_in,
  input  logic       clear,
  input  logic [1:0] win_sel,
  output logic       det
);
  import t1oof_pkg::*;

  localparam int unsigned WIN_MAX = BASE_WIN + 2;
  localparam int unsigned CNTW    = $clog2(WIN_MAX + 1);

  logic [WIN_MAX-1:0] hist_q;
  logic [WIN_MAX-1:0] hist_nx;
  logic [WIN_MAX-1:0] mask;
  logic [CNTW-1:0]    err_cnt;
  int unsigned        depth;

  assign hist_nx = {hist_q[WIN_MAX-2:0], err_in};
  assign depth   = win_depth(win_sel, BASE_WIN);

  for (genvar i = 0; i < WIN_MAX; i++) begin : g_mask
    assign mask[i] = (i < depth);
  end

  always_comb begin
    err_cnt = '0;
    for (int i = 0; i < WIN_MAX; i++) begin
      err_cnt = err_cnt + CNTW'(hist_nx[i] & mask[i]);
    end
  end

  assign det = shift_en && (err_cnt >= CNTW'(ERR_LIM));

  always_ff @(posedge clk) begin
    if (!rst_n)        hist_q <= '0;
    else if (clear)    hist_q <= '0;
    else if (shift_en) hist_q <= hist_nx;
  end
endmodule

// File: rtl/t1oof_trigger.sv
module t1oof_trigger (
  input  logic clk,
  input  logic rst_n,
  input  logic sw_req,
  input  logic auto_off,
  input  logic oof_only,
  input  logic carrier_loss,
  input  logic oof_det,
  output logic trig
);
  logic sw_q, cl_q;
  logic sw_edge, cl_edge, auto_trig;

  assign sw_edge   = sw_req & ~sw_q;
  assign cl_edge   = carrier_loss & ~cl_q;
  assign auto_trig = ~auto_off & (oof_det | (~oof_only & cl_edge));
  assign trig      = sw_edge | auto_trig;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sw_q <= 1'b0;
      cl_q <= 1'b0;
    end else begin
      sw_q <= sw_req;
      cl_q <= carrier_loss;
    end
  end
endmodule

// File: rtl/t1oof_qualifier.sv
module t1oof_qualifier #(
  parameter int unsigned SHORT_Q = 10,
  parameter int unsigned LONG_Q  = 24
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic oof_det,
  input  logic long_sel,
  input  logic cand_valid,
  input  logic cand_match,
  output logic oof,
  output logic in_sync,
  output logic resync_start,
  output logic qualified
);
  localparam int unsigned QW = $clog2(LONG_Q + 1);

  logic          srch_q;
  logic [QW-1:0] cnt_q;
  logic [QW-1:0] cnt_nx;
  logic [QW-1:0] target;

  assign target    = long_sel ? QW'(LONG_Q) : QW'(SHORT_Q);
  assign cnt_nx    = cnt_q + 1'b1;
  assign qualified = ~start & srch_q & cand_valid & cand_match & (cnt_nx == target);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      oof          <= 1'b1;
      in_sync      <= 1'b0;
      srch_q       <= 1'b0;
      cnt_q        <= '0;
      resync_start <= 1'b0;
    end else begin
      resync_start <= start;
      if (start) begin
        oof     <= 1'b1;
        in_sync <= 1'b0;
        srch_q  <= 1'b1;
        cnt_q   <= '0;
      end else begin
        if (oof_det) begin
          oof     <= 1'b1;
          in_sync <= 1'b0;
        end
        if (srch_q && cand_valid) begin
          if (!cand_match) begin
            cnt_q <= '0;
          end else if (qualified) begin
            srch_q  <= 1'b0;
            oof     <= 1'b0;
            in_sync <= 1'b1;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_nx;
          end
        end
      end
    end
  end
endmodule

// File: rtl/t1_oof_monitor.sv
module t1_oof_monitor #(
  parameter int unsigned BASE_WIN = 4,
  parameter int unsigned ERR_LIM  = 2,
  parameter int unsigned SHORT_Q  = 10,
  parameter int unsigned LONG_Q   = 24
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] ctrl_byte,
  input  logic       fbit_valid,
  input  logic       fbit_err,
  input  logic       carrier_loss,
  input  logic       cand_valid,
  input  logic       cand_match,
  output logic       oof,
  output logic       resync_start,
  output logic       in_sync,
  output logic       search_crit
);
  import t1oof_pkg::*;

  ctrl_t cfg;
  logic  oof_det, trig, qualified;

  assign cfg         = ctrl_t'(ctrl_byte);
  assign search_crit = cfg.crit;

  t1oof_err_window #(.BASE_WIN(BASE_WIN), .ERR_LIM(ERR_LIM)) u_win (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (fbit_valid & ~oof),
    .err_in   (fbit_err),
    .clear    (trig | qualified),
    .win_sel  (cfg.win_sel),
    .det      (oof_det)
  );

  t1oof_trigger u_trig (
    .clk          (clk),
    .rst_n        (rst_n),
    .sw_req       (cfg.sw_req),
    .auto_off     (cfg.auto_off),
    .oof_only     (cfg.oof_only),
    .carrier_loss (carrier_loss),
    .oof_det      (oof_det),
    .trig         (trig)
  );

  t1oof_qualifier #(.SHORT_Q(SHORT_Q), .LONG_Q(LONG_Q)) u_qual (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (trig),
    .oof_det      (oof_det),
    .long_sel     (cfg.long_qual),
    .cand_valid   (cand_valid),
    .cand_match   (cand_match),
    .oof          (oof),
    .in_sync      (in_sync),
    .resync_start (resync_start),
    .qualified    (qualified)
  );
endmodule

// File: rtl/t1_oof_monitor_chk.sv
module t1_oof_monitor_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] ctrl_byte,
  input logic       fbit_valid,
  input logic       cand_valid,
  input logic       cand_match,
  input logic       oof,
  input logic       resync_start,
  input logic       in_sync
);
  logic [1:0] since_rst;

  always_ff @(posedge clk) begin
    if (!rst_n)               since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  // R10
  oof_insync_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(oof && in_sync));

  // R7
  pulse_sets_oof_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resync_start |-> (oof && !in_sync));

  // R6
  lock_from_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 2'd1 && $rose(in_sync)) |-> $past(cand_valid && cand_match));

  // R10
  oof_fall_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 2'd1 && $fell(oof)) |-> in_sync);

  // R3
  oof_from_fbit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 2'd1 && $rose(oof) && !resync_start) |-> $past(fbit_valid));

  // R2
  sw_edge_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 2'd2 && resync_start && $past(ctrl_byte[1]))
      |-> ($past(ctrl_byte[0]) && !$past(ctrl_byte[0], 2)));
endmodule

bind t1_oof_monitor t1_oof_monitor_chk chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .ctrl_byte    (ctrl_byte),
  .fbit_valid   (fbit_valid),
  .cand_valid   (cand_valid),
  .cand_match   (cand_match),
  .oof          (oof),
  .resync_start (resync_start),
  .in_sync      (in_sync)
);

// File: tb/t1_oof_monitor_tb_top.sv
`timescale 1ns/1ps
module t1_oof_monitor_tb_top;
  localparam logic [7:0] SW = 8'h01, AOFF = 8'h02, LONG = 8'h04, CRIT = 8'h08;
  localparam logic [7:0] SEL5 = 8'h10, SEL6 = 8'h20, SEL7 = 8'h30, ARC = 8'h40, B7 = 8'h80;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] ctrl = 8'h00;
  logic fv = 0, fe = 0, cl = 0, cv = 0, cm = 0;
  logic oof, rs, insync, crit;

  int checks = 0, fails = 0;
  string cur_req = "R1";

  always #2 clk = ~clk;

  t1_oof_monitor dut_i (
    .clk(clk), .rst_n(rst_n), .ctrl_byte(ctrl), .fbit_valid(fv), .fbit_err(fe),
    .carrier_loss(cl), .cand_valid(cv), .cand_match(cm), .oof(oof),
    .resync_start(rs), .in_sync(insync), .search_crit(crit)
  );

  // Behavioural reference model
  bit m_oof = 1, m_sync = 0, m_srch = 0, m_pulse = 0, prev_sw = 0, prev_cl = 0;
  bit err_q[$];
  int qual = 0;

  task automatic model_step();
    bit det = 0, swe, cle, trig;
    int depth, n;
    if (!m_oof && fv) begin
      err_q.push_back(fe);
      if (err_q.size() > 6) void'(err_q.pop_front());
      depth = (ctrl[5:4] == 2'd0) ? 4 : (ctrl[5:4] == 2'd1) ? 5 : 6;
      n = 0;
      for (int i = 0; i < err_q.size(); i++)
        if (i >= err_q.size() - depth && err_q[i]) n++;
      det = (n >= 2);
    end
    swe  = ctrl[0] && !prev_sw;
    cle  = cl && !prev_cl;
    trig = swe || (!ctrl[1] && (det || (!ctrl[6] && cle)));
    m_pulse = trig;
    if (trig) begin
      m_oof = 1; m_sync = 0; m_srch = 1; qual = 0; err_q.delete();
    end else begin
      if (det) begin m_oof = 1; m_sync = 0; end
      if (m_srch && cv) begin
        if (cm) begin
          qual++;
          if (qual == (ctrl[2] ? 24 : 10)) begin
            m_srch = 0; m_oof = 0; m_sync = 1; qual = 0; err_q.delete();
          end
        end else qual = 0;
      end
    end
    prev_sw = ctrl[0];
    prev_cl = cl;
  endtask

  task automatic chk(string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s at %0t: actual %0b expected %0b", cur_req, what, $time, act, exp);
    end
  endtask

  task automatic compare();
    chk("oof", oof, m_oof);
    chk("resync_start", rs, m_pulse);
    chk("in_sync", insync, m_sync);
    chk("search_crit (R9)", crit, ctrl[3]);
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    model_step();
    compare();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic fbit(bit e);
    fv = 1; fe = e; tick(); fv = 0; fe = 0;
  endtask

  task automatic cand(bit m);
    cv = 1; cm = m; tick(); cv = 0; cm = 0;
  endtask

  task automatic qualify(int n);
    for (int i = 0; i < n; i++) cand(1);
    idle(1);
  endtask

  // soft resync: drop bit 0 then raise it, keeping other bits in base
  task automatic soft_resync(logic [7:0] base);
    ctrl = base; tick();
    ctrl = base | SW; tick();
    ctrl = base; tick();
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    checks++;
    $display("FAIL watchdog expired expected completion");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state, idle with no request
    cur_req = "R1";
    compare();
    idle(4);

    // R2: soft edge launches, held level does not
    cur_req = "R2";
    ctrl = AOFF; tick();
    ctrl = AOFF | SW; idle(6);
    cur_req = "R6";
    qualify(10);
    cur_req = "R2";
    idle(3);
    ctrl = AOFF; tick();
    ctrl = AOFF | SW; tick();
    ctrl = AOFF;
    cur_req = "R6";
    for (int i = 0; i < 5; i++) cand(1);
    cand(0);
    qualify(10);

    // R3: window depths, auto disabled
    cur_req = "R3";
    fbit(1); fbit(0); fbit(0); fbit(1); idle(2);
    soft_resync(AOFF); qualify(10);
    ctrl = AOFF; fbit(1); fbit(0); fbit(0); fbit(0); fbit(1); fbit(0); idle(1);
    fbit(1); idle(2);
    fbit(1); fbit(1); idle(2);          // ignored while oof
    soft_resync(AOFF | SEL5); qualify(10);
    fbit(1); fbit(0); fbit(0); fbit(0); fbit(1); idle(2);
    soft_resync(AOFF | SEL6); qualify(10);
    fbit(1); fbit(0); fbit(0); fbit(0); fbit(0); fbit(0); fbit(1); idle(1);
    fbit(0); fbit(1); idle(2);
    soft_resync(AOFF | SEL7); qualify(10);
    fbit(1); fbit(0); fbit(0); fbit(0); fbit(0); fbit(1); idle(2);

    // R4: auto resync on declaration
    cur_req = "R4";
    soft_resync(8'h00); qualify(10);
    fbit(1); fbit(1); idle(2);
    qualify(10);

    // R5: carrier loss trigger and its mask
    cur_req = "R5";
    cl = 1; idle(4); cl = 0; idle(1);
    qualify(10);
    ctrl = ARC; idle(1);
    cl = 1; idle(3); cl = 0; idle(2);
    ctrl = AOFF; cl = 1; idle(2); cl = 0; idle(2);

    // R6: long qualification with mismatch restart
    cur_req = "R6";
    ctrl = LONG; cl = 1; tick(); cl = 0; idle(1);
    for (int i = 0; i < 20; i++) cand(1);
    cand(0);
    for (int i = 0; i < 23; i++) cand(1);
    idle(1);
    cand(1); idle(2);

    // R7: coincident triggers, restart during search
    cur_req = "R7";
    ctrl = 8'h00; fbit(1);
    ctrl = SW; fv = 1; fe = 1; tick(); fv = 0; fe = 0; ctrl = 8'h00; idle(2);
    for (int i = 0; i < 7; i++) cand(1);
    cl = 1; tick(); cl = 0;
    for (int i = 0; i < 9; i++) cand(1);
    idle(1);
    cand(1); idle(2);

    // R8: history emptied on launch and on qualification
    cur_req = "R8";
    fbit(1); fbit(0);
    soft_resync(8'h00); qualify(10);
    fbit(1); fbit(0); fbit(0); idle(2);

    // R9: criterion passthrough, reserved bit ignored
    cur_req = "R9";
    ctrl = CRIT; idle(2);
    ctrl = CRIT | B7; fbit(0); fbit(1); idle(2);
    ctrl = B7; fbit(0); fbit(0); idle(2);

    // R10: oof holds until qualified
    cur_req = "R10";
    ctrl = AOFF; fbit(1); fbit(1); idle(8);
    for (int i = 0; i < 9; i++) cand(1);
    idle(3);

    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule